// File: doc/BRIEF.md
# Banked Interrupt Controller with Edge Latching

This block gathers 64 interrupt lines into two banks of 32 and drives one interrupt request toward a processor, or toward a parent controller when it sits in a cascade. Each line passes through a two-flop synchronizer. A rising edge on an enabled line sets a sticky event flag. Software clears that flag by writing a one to the matching acknowledge bit. The synchronized line state can be read back directly, so software can tell that a level-style source is still asserted.

The request output is raised only by latched events. Turning on an enable bit while its line is already high therefore produces no request and no event. Only a fresh rising edge after the enable is set produces one. A separate read-only helper reports the highest-numbered pending source. For this helper a source is pending when its event flag or its live line is set, and its enable bit is also set.

Register access uses a small bus with a byte address, a write strobe and a read strobe. Read data returns one cycle after the read strobe. A two-state bus sequencer tracks this: `BUS_IDLE` moves to `BUS_RESP` on a read strobe. `BUS_RESP` stays in `BUS_RESP` on a back-to-back read, and otherwise returns to `BUS_IDLE`.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Sources 0..31 form the bank at byte offset 0x20 and sources 32..63 form the bank at 0x10. Source n is bit n&31 of its bank. Within a bank, address bits [3:2] select the register: 0 = event, 1 = enable, 2 = ack, 3 = level. Read data appears on `bus_rdata_o` with `bus_rvalid_o` high in the cycle after `bus_rd_i`.
- R2: The level register returns the synchronized line state, two clocks behind the pin, whatever the enable setting.
- R3: A rising edge on a line whose enable bit is set sets its event flag. An edge on a disabled line sets nothing.
- R4: Writing the ack register clears each event flag whose bit is written as 1. Bits written as 0, and the other bank, are unchanged.
- R5: When an ack write and a new rising edge hit the same bit in the same cycle, the event flag stays set.
- R6: Setting an enable bit while its line is already high sets no event flag and leaves `irq_o` low. A later rising edge sets the flag.
- R7: `irq_o` is a registered OR of (event AND enable) over both banks. It rises one clock after the event flag is set, which is four clocks after the pin rises.
- R8: `pend_valid_o`/`pend_idx_o` give the highest-numbered source with (event OR level) AND enable. Any pending bit in the upper bank wins over the lower bank. When nothing is pending, the valid output is 0 and the index is 0.
- R9: After reset, every register reads 0 and `irq_o` and `pend_valid_o` are low. Once both enable registers are written with 0, neither output can assert, even if event flags remain set.
- R10: Writes to the event or level registers, and to unmapped offsets (0x00..0x0F, 0x30..0x3F), change no state. Reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 64 | Raw interrupt lines, bit n = source n |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 6 | Byte address in the 64-byte window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| irq_o | output | 1 | Registered interrupt request |
| pend_valid_o | output | 1 | Some enabled source is pending |
| pend_idx_o | output | 6 | Highest pending source number |

## Verification
A corrupted event flag shows up at `irq_o` one clock after the flag register updates. It also appears in the event register on the next read. A stuck or missing synchronizer stage shifts the level readback and the `irq_o` rise by one clock from the expected four. The bench samples at that exact cycle. A wrong enable or bank decode moves `pend_idx_o` at once, because the helper is combinational on the stored state. A wrong ack or edge priority leaves a flag with the wrong value, which the next read of that bank shows.

// File: rtl/bic_pkg.sv
package bic_pkg;
    localparam int BANK_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    // Address bits [5:4] that select a bank: bank 0 at 0x20, bank 1 at 0x10.
    function automatic logic [1:0] bank_slot(input int b);
        return 2'(2 - b);
    endfunction
endpackage

// File: rtl/bic_bank.sv
module bic_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    input  logic         en_we_i,
    input  logic         ack_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] evt_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] req_o,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] sync1_q, sync2_q, prev_q;
    logic [W-1:0] evt_q, en_q;
    logic [W-1:0] rise, set_vec, clr_vec;

    assign rise    = sync2_q & ~prev_q;
    assign set_vec = rise & en_q;
    assign clr_vec = ack_we_i ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= line_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
            en_q  <= '0;
        end else begin
            evt_q <= (evt_q & ~clr_vec) | set_vec;
            if (en_we_i) en_q <= wdata_i;
        end
    end

    assign evt_o  = evt_q;
    assign en_o   = en_q;
    assign lvl_o  = sync2_q;
    assign req_o  = evt_q & en_q;
    assign pend_o = (evt_q | sync2_q) & en_q;

    // R4: acknowledged bits without a coincident edge are clear next cycle
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we_i |=> ((evt_q & $past(wdata_i) & ~$past(set_vec)) == '0));

    // R3: a flag only appears after an enabled, synchronized high line
    p_evt_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~$past(evt_q) & ~$past(sync2_q & en_q)) == '0));

    // R5: an edge seen on an enabled bit is never lost
    p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(rise & en_q) & ~evt_q) == '0));
endmodule

// File: rtl/bic_prio.sv
module bic_prio #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    // Ascending scan: the last hit is the highest number, so the upper bank wins.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import bic_pkg::*;
#(
    parameter  int NUM_BANKS = 2,
    parameter  int ADDR_W    = 6,
    localparam int SRC_N     = NUM_BANKS * BANK_W,
    localparam int IDX_W     = $clog2(SRC_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  irq_lines_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              irq_o,
    output logic              pend_valid_o,
    output logic [IDX_W-1:0]  pend_idx_o
);
    reg_sel_e             reg_sel;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [BANK_W-1:0]    evt_w [NUM_BANKS];
    logic [BANK_W-1:0]    en_w  [NUM_BANKS];
    logic [BANK_W-1:0]    lvl_w [NUM_BANKS];
    logic [SRC_N-1:0]     req_all, pend_all, en_all;
    logic [DATA_W-1:0]    rd_mux, rdata_q;
    logic                 irq_q;
    bus_state_e           state_q, state_d;
    logic                 unused_addr_lo;

    assign unused_addr_lo = ^bus_addr_i[1:0];
    assign reg_sel        = reg_sel_e'(bus_addr_i[3:2]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] req_b, pend_b;

        assign bank_hit[b] = (bus_addr_i[ADDR_W-1:ADDR_W-2] == bank_slot(b));

        bic_bank #(.W(BANK_W)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_i   (irq_lines_i[b*BANK_W +: BANK_W]),
            .en_we_i  (bus_wr_i && bank_hit[b] && reg_sel == REG_ENABLE),
            .ack_we_i (bus_wr_i && bank_hit[b] && reg_sel == REG_ACK),
            .wdata_i  (bus_wdata_i[BANK_W-1:0]),
            .evt_o    (evt_w[b]),
            .en_o     (en_w[b]),
            .lvl_o    (lvl_w[b]),
            .req_o    (req_b),
            .pend_o   (pend_b)
        );

        assign req_all[b*BANK_W +: BANK_W]  = req_b;
        assign pend_all[b*BANK_W +: BANK_W] = pend_b;
        assign en_all[b*BANK_W +: BANK_W]   = en_w[b];
    end

    bic_prio #(.N(SRC_N), .IDX_W(IDX_W)) prio_i (
        .pend_i  (pend_all),
        .valid_o (pend_valid_o),
        .idx_o   (pend_idx_o)
    );

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                unique case (reg_sel)
                    REG_EVENT:  rd_mux = DATA_W'(evt_w[b]);
                    REG_ENABLE: rd_mux = DATA_W'(en_w[b]);
                    REG_ACK:    rd_mux = '0;
                    REG_LEVEL:  rd_mux = DATA_W'(lvl_w[b]);
                endcase
            end
        end
    end

    // Bus sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = bus_rd_i ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = bus_rd_i ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // Outputs: read data capture and registered request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (bus_rd_i) rdata_q <= rd_mux;
            irq_q <= |req_all;
        end
    end

    assign bus_rdata_o  = rdata_q;
    assign bus_rvalid_o = (state_q == BUS_RESP);
    assign irq_o        = irq_q;

    // R1: a read strobe is answered in the next cycle
    p_rvalid_follows_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_i |=> bus_rvalid_o);

    // R9: with every enable clear, the request must be low next cycle
    p_irq_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |=> !irq_o);

    // R8: the reported index points at a pending source
    p_idx_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o |-> pend_all[pend_idx_o]);

    // R8: nothing pending reports index zero
    p_idx_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid_o |-> (pend_idx_o == '0 && pend_all == '0));
endmodule

// File: tb/banked_irq_ctrl_tb_top.sv
module banked_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] B0 = 6'h20;
    localparam logic [5:0] B1 = 6'h10;
    localparam logic [5:0] O_EVT = 6'h0;
    localparam logic [5:0] O_EN  = 6'h4;
    localparam logic [5:0] O_ACK = 6'h8;
    localparam logic [5:0] O_LVL = 6'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] lines = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid, irq, pvalid;
    logic [5:0]  pidx;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq),
        .pend_valid_o(pvalid), .pend_idx_o(pidx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        check("R1 rvalid", 32'(rvalid), 32'd1);
        d = rdata;
    endtask

    task automatic expect_reg(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        check("R9 irq after reset", 32'(irq), 0);
        check("R9 pend_valid after reset", 32'(pvalid), 0);
        expect_reg("R9 enable bank0", B0 + O_EN, 0);
        expect_reg("R9 event bank1", B1 + O_EVT, 0);
    endtask

    task automatic t_level();
        @(negedge clk);
        lines[5] = 1'b1; lines[40] = 1'b1;
        wait_clk(3);
        expect_reg("R2 level bank0", B0 + O_LVL, 32'h1 << 5);
        expect_reg("R2 level bank1 (R1 map)", B1 + O_LVL, 32'h1 << 8);
        expect_reg("R3 disabled edge no event", B0 + O_EVT, 0);
        check("R3 irq stays low", 32'(irq), 0);
        lines[5] = 1'b0; lines[40] = 1'b0;
        wait_clk(3);
    endtask

    task automatic t_edge_irq();
        bus_write(B0 + O_EN, 32'h1 << 3);
        wait_clk(1);
        lines[3] = 1'b1;
        wait_clk(3);
        check("R7 irq not before fourth clock", 32'(irq), 0);
        wait_clk(1);
        check("R7 irq on fourth clock", 32'(irq), 1);
        expect_reg("R3 event set", B0 + O_EVT, 32'h1 << 3);
        check("R8 pending index 3", {pvalid, 25'd0, pidx}, {1'b1, 25'd0, 6'd3});
    endtask

    task automatic t_ack();
        lines[3] = 1'b0;
        wait_clk(3);
        bus_write(B0 + O_ACK, 32'h0);
        expect_reg("R4 zero ack keeps flag", B0 + O_EVT, 32'h1 << 3);
        bus_write(B1 + O_EN, 32'h1 << 8);
        lines[40] = 1'b1;
        wait_clk(5);
        lines[40] = 1'b0;
        bus_write(B0 + O_ACK, 32'h1 << 3);
        expect_reg("R4 ack clears bank0", B0 + O_EVT, 0);
        expect_reg("R4 other bank untouched", B1 + O_EVT, 32'h1 << 8);
        check("R7 irq held by bank1", 32'(irq), 1);
        bus_write(B1 + O_ACK, 32'h1 << 8);
        wait_clk(1);
        check("R7 irq drops after ack", 32'(irq), 0);
        bus_write(B1 + O_EN, 0);
        wait_clk(3);
    endtask

    task automatic t_enable_high();
        lines[50] = 1'b1;
        wait_clk(4);
        bus_write(B1 + O_EN, 32'h1 << 18);
        wait_clk(4);
        expect_reg("R6 no event on enable", B1 + O_EVT, 0);
        check("R6 no irq on enable", 32'(irq), 0);
        check("R8 level counts as pending", {pvalid, 25'd0, pidx}, {1'b1, 25'd0, 6'd50});
        lines[50] = 1'b0;
        wait_clk(4);
        check("R8 nothing pending", {pvalid, 25'd0, pidx}, 32'd0);
        lines[50] = 1'b1;
        wait_clk(5);
        expect_reg("R6 later edge sets event", B1 + O_EVT, 32'h1 << 18);
        check("R6 later edge raises irq", 32'(irq), 1);
        lines[50] = 1'b0;
        bus_write(B1 + O_ACK, 32'h1 << 18);
        bus_write(B1 + O_EN, 0);
        wait_clk(3);
    endtask

    task automatic t_edge_wins();
        lines[3] = 1'b1;
        wait_clk(5);
        lines[3] = 1'b0;
        wait_clk(4);
        expect_reg("R5 flag set before race", B0 + O_EVT, 32'h1 << 3);
        @(negedge clk);
        lines[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr = 1'b1; addr = B0 + O_ACK; wdata = 32'h1 << 3;
        @(negedge clk);
        wr = 1'b0;
        expect_reg("R5 edge beats ack", B0 + O_EVT, 32'h1 << 3);
        lines[3] = 1'b0;
        wait_clk(3);
        bus_write(B0 + O_ACK, 32'h1 << 3);
        expect_reg("R4 ack clears after race", B0 + O_EVT, 0);
    endtask

    task automatic t_prio();
        bus_write(B0 + O_EN, 32'hFFFF_FFFF);
        bus_write(B1 + O_EN, 32'hFFFF_FFFF);
        lines[10] = 1'b1; lines[45] = 1'b1;
        wait_clk(5);
        check("R8 upper bank first", {26'd0, pidx}, 32'd45);
        lines[63] = 1'b1;
        wait_clk(5);
        check("R8 highest source", {26'd0, pidx}, 32'd63);
        lines[10] = 1'b0; lines[45] = 1'b0; lines[63] = 1'b0;
        wait_clk(4);
        check("R8 latched events still rank", {pvalid, 25'd0, pidx}, {1'b1, 25'd0, 6'd63});
        bus_write(B1 + O_ACK, 32'h1 << 31);
        check("R8 next after ack", {26'd0, pidx}, 32'd45);
        bus_write(B1 + O_ACK, 32'h1 << 13);
        check("R8 falls to lower bank", {26'd0, pidx}, 32'd10);
    endtask

    task automatic t_ignored();
        bus_write(B0 + O_EVT, 32'hFFFF_FFFF);
        bus_write(B0 + O_LVL, 32'hFFFF_FFFF);
        bus_write(6'h04, 32'h0);
        bus_write(6'h34, 32'h0);
        expect_reg("R10 event write ignored", B0 + O_EVT, 32'h1 << 10);
        expect_reg("R10 level write ignored", B0 + O_LVL, 0);
        expect_reg("R10 unmapped write left enable", B0 + O_EN, 32'hFFFF_FFFF);
        expect_reg("R10 unmapped low reads 0", 6'h04, 0);
        expect_reg("R10 unmapped high reads 0", 6'h34, 0);
        check("R7 irq from latched event", 32'(irq), 1);
    endtask

    task automatic t_disable_all();
        bus_write(B0 + O_EN, 0);
        bus_write(B1 + O_EN, 0);
        wait_clk(1);
        check("R9 irq low when all disabled", 32'(irq), 0);
        check("R9 nothing pending when disabled", 32'(pvalid), 0);
        lines[20] = 1'b1;
        wait_clk(5);
        check("R9 edge while disabled no irq", 32'(irq), 0);
        expect_reg("R9 flags kept but silent", B0 + O_EVT, 32'h1 << 10);
        lines[20] = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_clk(1);
        t_reset();
        t_level();
        t_edge_irq();
        t_ack();
        t_enable_high();
        t_edge_wins();
        t_prio();
        t_ignored();
        t_disable_all();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule